// File: doc/BRIEF.md
# Indirect Configuration and IO Access Gateway

This block lets a processor reach expansion-bus configuration space and IO space through three registers on its own register bus: an address register, a configuration data window and an IO data window. A load or store to either window is turned into one request on a simple downstream interface. That request carries the target address, a byte count code, the direction, the write data and the target space. The block then waits for the downstream side to acknowledge and returns the read data and error status to the processor.

The two windows share the single address register. A configuration access targets the register value with the low two offset bits of the access ORed in. An IO access uses only the low 16 bits of the register as its port address. Each access is also checked against a legality matrix of offset and size. An illegal access is answered at once with an error and never reaches the downstream side.

On the downstream side, byte lanes are little-endian: the byte at the lowest address sits in bits 7:0. On the register bus, data is right-justified by value. The configuration window passes a value through unchanged. The IO window reverses the byte order within the access size.

Top module: `cfgio_gate`

## Requirements
- R1: After reset, `rsp_o` and `dn_req_o` are low and the address register reads as 0.
- R2: A 4-byte access at offset 0x064 writes or reads the full 32-bit address register, responds without error and issues no downstream request.
- R3: A configuration window access (offsets 0x068 to 0x06B) issues `dn_space_o`=0 with `dn_addr_o` equal to the address register ORed with the offset bits 1:0. Bit 31 of the register plays no gating role.
- R4: Configuration window data passes unreordered. Write data and read data are masked to the access size, where `size_i` 0/1/2 means 1/2/4 bytes.
- R5: An IO window access (offsets 0x06C to 0x06F) issues `dn_space_o`=1 with `dn_addr_o` equal to the low 16 bits of the address register, zero-extended. The offset bits 1:0 do not enter the address.
- R6: IO window data is byte-reversed within the access size on both writes and reads, and the result is zero above the size.
- R7: Within each data window, a 4-byte access is legal only at the window base. A 2-byte access is legal at base or base+2. A 1-byte access is legal at any of the four offsets.
- R8: Size code 3, an offset outside 0x064 to 0x06F, or a non-4-byte or unaligned access to the address register is rejected. A rejected access gets `err_o`=1 and `rdata_o`=0 on its response and produces no downstream request.
- R9: A window access stalls until `dn_ack_i`. `rsp_o` pulses for one cycle in the cycle after the acknowledge and carries `dn_err_i` on `err_o`. A rejected or address-register access responds in the cycle after it is accepted.
- R10: `dn_req_o` stays high, with address and write data unchanged, until the cycle in which `dn_ack_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, held until `rsp_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | 12 | Register byte offset |
| size_i | input | 2 | Byte count code: 0=1, 1=2, 2=4, 3=illegal |
| wdata_i | input | 32 | Write value, right-justified |
| rsp_o | output | 1 | One-cycle response strobe |
| rdata_o | output | 32 | Read value, right-justified |
| err_o | output | 1 | Error flag for the response |
| dn_req_o | output | 1 | Downstream request |
| dn_space_o | output | 1 | 0 = configuration, 1 = IO |
| dn_we_o | output | 1 | Downstream direction |
| dn_size_o | output | 2 | Downstream byte count code |
| dn_addr_o | output | 32 | Downstream address |
| dn_wdata_o | output | 32 | Downstream write data, little-endian lanes |
| dn_ack_i | input | 1 | Downstream acknowledge |
| dn_err_i | input | 1 | Downstream error, valid with ack |
| dn_rdata_i | input | 32 | Downstream read data, little-endian lanes |

## Verification
Several properties are checked by assertions on every cycle:
- the request is held, with stable address and data, until it is acknowledged;
- the response follows the acknowledge and lasts a single cycle;
- a downstream request starts only for an access the decoder found legal;
- a rejected response carries zero data;
- the IO address has no upper bits;
- the address register changes only on an accepted register write.

Other behaviours only the directed scenarios can show: the exact address formed for each window, the byte reversal for each size, the full legality matrix and the measured stall latency against a delayed acknowledge.

// File: rtl/cfgio_gate_pkg.sv
package cfgio_gate_pkg;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_AREG,
    KIND_CFG,
    KIND_IO
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_RESP
  } state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00ff;
      SZ_HALF: size_mask = 32'h0000_ffff;
      default: size_mask = 32'hffff_ffff;
    endcase
  endfunction

endpackage

// File: rtl/cfgio_gate_decode.sv
module cfgio_gate_decode
  import cfgio_gate_pkg::*;
#(
  parameter int unsigned    OFF_W    = 12,
  parameter logic [OFF_W-1:0] AREG_OFF = 'h064,
  parameter logic [OFF_W-1:0] CFG_OFF  = 'h068,
  parameter logic [OFF_W-1:0] IO_OFF   = 'h06C
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output kind_e            kind_o,
  output logic             legal_o
);

  logic [OFF_W-1:0] base;
  logic [1:0]       lo;
  logic             aligned;

  assign base = {off_i[OFF_W-1:2], 2'b00};
  assign lo   = off_i[1:0];

  // natural alignment inside a 4-byte window
  always_comb begin
    case (size_i)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = ~lo[0];
      SZ_WORD: aligned = (lo == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

  always_comb begin
    kind_o  = KIND_NONE;
    legal_o = 1'b0;
    if (base == AREG_OFF) begin
      kind_o  = KIND_AREG;
      legal_o = (size_i == SZ_WORD) && (lo == 2'b00);
    end else if (base == CFG_OFF) begin
      kind_o  = KIND_CFG;
      legal_o = aligned;
    end else if (base == IO_OFF) begin
      kind_o  = KIND_IO;
      legal_o = aligned;
    end
  end

endmodule

// File: rtl/cfgio_gate_lane.sv
module cfgio_gate_lane #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic              swap_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned NB = DATA_W / 8;

  int nb;
  assign nb = 1 << size_i;

  for (genvar gi = 0; gi < NB; gi++) begin : g_lane
    logic [7:0] b;
    always_comb begin
      b = 8'h00;
      if (gi < nb) begin
        if (!swap_i) begin
          b = data_i[gi*8 +: 8];
        end else begin
          for (int j = 0; j < NB; j++) begin
            if (j == nb - 1 - gi) b = data_i[j*8 +: 8];
          end
        end
      end
    end
    assign data_o[gi*8 +: 8] = b;
  end

endmodule

// File: rtl/cfgio_gate_ctrl.sv
module cfgio_gate_ctrl
  import cfgio_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  kind_e             kind_i,
  input  logic              legal_i,
  input  logic [DATA_W-1:0] areg_i,
  input  logic [DATA_W-1:0] dn_rd_i,
  input  logic              dn_ack_i,
  input  logic              dn_err_i,
  output logic              launch_o,
  output logic              areg_we_o,
  output logic              dn_req_o,
  output logic              rsp_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);

  state_e            state_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              accept;

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign launch_o  = accept && legal_i && (kind_i != KIND_AREG);
  assign areg_we_o = accept && legal_i && (kind_i == KIND_AREG) && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (!legal_i) begin
              state_q <= ST_RESP;
              rdata_q <= '0;
              err_q   <= 1'b1;
            end else if (kind_i == KIND_AREG) begin
              state_q <= ST_RESP;
              rdata_q <= we_i ? '0 : areg_i;
              err_q   <= 1'b0;
            end else begin
              state_q <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (dn_ack_i) begin
            state_q <= ST_RESP;
            rdata_q <= dn_rd_i;
            err_q   <= dn_err_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dn_req_o = (state_q == ST_BUSY);
  assign rsp_o    = (state_q == ST_RESP);
  assign rdata_o  = rdata_q;
  assign err_o    = err_q;

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && !dn_ack_i |=> dn_req_o);

  // R9
  rsp_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && dn_ack_i |=> rsp_o && !dn_req_o);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_o |=> !rsp_o);

  // R8
  launch_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_req_o) |-> $past(legal_i));

  // R8
  reject_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_o && err_o && !$past(dn_req_o) |-> rdata_o == '0);

endmodule

// File: rtl/cfgio_gate.sv
module cfgio_gate
  import cfgio_gate_pkg::*;
#(
  parameter int unsigned      OFF_W     = 12,
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      IO_ADDR_W = 16,
  parameter logic [OFF_W-1:0] AREG_OFF  = 'h064,
  parameter logic [OFF_W-1:0] CFG_OFF   = 'h068,
  parameter logic [OFF_W-1:0] IO_OFF    = 'h06C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rsp_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              dn_req_o,
  output logic              dn_space_o,
  output logic              dn_we_o,
  output logic [1:0]        dn_size_o,
  output logic [DATA_W-1:0] dn_addr_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic              dn_ack_i,
  input  logic              dn_err_i,
  input  logic [DATA_W-1:0] dn_rdata_i
);

  localparam int unsigned IO_PAD_W = DATA_W - IO_ADDR_W;

  kind_e             kind;
  logic              legal;
  logic              launch;
  logic              areg_we;
  logic [DATA_W-1:0] areg_q;
  logic [DATA_W-1:0] wr_lane;
  logic [DATA_W-1:0] rd_lane;
  logic [DATA_W-1:0] next_addr;
  logic              is_io;

  cfgio_gate_decode #(
    .OFF_W   (OFF_W),
    .AREG_OFF(AREG_OFF),
    .CFG_OFF (CFG_OFF),
    .IO_OFF  (IO_OFF)
  ) decode_i (
    .off_i  (off_i),
    .size_i (size_i),
    .kind_o (kind),
    .legal_o(legal)
  );

  assign is_io = (kind == KIND_IO);

  // IO port address ignores the window offset bits
  assign next_addr = is_io ? {{IO_PAD_W{1'b0}}, areg_q[IO_ADDR_W-1:0]}
                           : (areg_q | {{(DATA_W-2){1'b0}}, off_i[1:0]});

  cfgio_gate_lane #(.DATA_W(DATA_W)) wr_lane_i (
    .data_i(wdata_i),
    .size_i(size_i),
    .swap_i(is_io),
    .data_o(wr_lane)
  );

  cfgio_gate_lane #(.DATA_W(DATA_W)) rd_lane_i (
    .data_i(dn_rdata_i),
    .size_i(dn_size_o),
    .swap_i(dn_space_o),
    .data_o(rd_lane)
  );

  cfgio_gate_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .kind_i   (kind),
    .legal_i  (legal),
    .areg_i   (areg_q),
    .dn_rd_i  (rd_lane),
    .dn_ack_i (dn_ack_i),
    .dn_err_i (dn_err_i),
    .launch_o (launch),
    .areg_we_o(areg_we),
    .dn_req_o (dn_req_o),
    .rsp_o    (rsp_o),
    .rdata_o  (rdata_o),
    .err_o    (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      areg_q <= '0;
    end else if (areg_we) begin
      areg_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dn_space_o <= 1'b0;
      dn_we_o    <= 1'b0;
      dn_size_o  <= SZ_BYTE;
      dn_addr_o  <= '0;
      dn_wdata_o <= '0;
    end else if (launch) begin
      dn_space_o <= is_io;
      dn_we_o    <= we_i;
      dn_size_o  <= size_i;
      dn_addr_o  <= next_addr;
      dn_wdata_o <= we_i ? wr_lane : '0;
    end
  end

  // R10
  dn_fields_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && !dn_ack_i |=> $stable(dn_addr_o) && $stable(dn_wdata_o) && $stable(dn_size_o));

  // R5
  io_addr_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && dn_space_o |-> dn_addr_o[DATA_W-1:IO_ADDR_W] == '0);

  // R2
  areg_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(areg_q) |-> $past(req_i && we_i && rsp_o == 1'b0 && dn_req_o == 1'b0 &&
                               off_i == AREG_OFF && size_i == SZ_WORD));

endmodule

// File: tb/cfgio_gate_tb_top.sv
module cfgio_gate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] off = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        rsp, err;
  logic [31:0] rdata;
  logic        dn_req, dn_space, dn_we;
  logic [1:0]  dn_size;
  logic [31:0] dn_addr, dn_wdata;
  logic        dn_ack = 1'b0;
  logic        dn_err = 1'b0;
  logic [31:0] dn_rdata = '0;

  int checks = 0;
  int errors = 0;

  // downstream model controls and captures
  int          dly = 0;
  logic        resp_err = 1'b0;
  logic [31:0] resp_data = '0;
  int          dn_count = 0;
  int          req_cycles = 0;
  logic        cap_space, cap_we;
  logic [1:0]  cap_size;
  logic [31:0] cap_addr, cap_wdata;

  always #5 clk = ~clk;

  cfgio_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .off_i(off),
    .size_i(size), .wdata_i(wdata), .rsp_o(rsp), .rdata_o(rdata), .err_o(err),
    .dn_req_o(dn_req), .dn_space_o(dn_space), .dn_we_o(dn_we),
    .dn_size_o(dn_size), .dn_addr_o(dn_addr), .dn_wdata_o(dn_wdata),
    .dn_ack_i(dn_ack), .dn_err_i(dn_err), .dn_rdata_i(dn_rdata)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  // downstream responder
  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (dn_ack) begin
        dn_ack = 1'b0;
      end else if (dn_req) begin
        req_cycles++;
        if (wcnt == 0) begin
          cap_space = dn_space; cap_we = dn_we; cap_size = dn_size;
          cap_addr = dn_addr; cap_wdata = dn_wdata;
        end else begin
          chk(dn_addr == cap_addr && dn_wdata == cap_wdata, "R10 fields held", dn_addr, cap_addr);
        end
        if (wcnt >= dly) begin
          dn_ack = 1'b1; dn_err = resp_err; dn_rdata = resp_data;
          dn_count++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic access(input logic [11:0] o, input logic [1:0] s, input logic w,
                        input logic [31:0] d, output logic [31:0] rd, output logic er,
                        output int lat);
    @(negedge clk);
    req_cycles = 0;
    req = 1'b1; we = w; off = o; size = s; wdata = d;
    lat = 0; rd = '0; er = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      lat++;
      if (rsp) begin
        rd = rdata; er = err;
        break;
      end
    end
    req = 1'b0;
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] v, input logic [1:0] s);
    case (s)
      2'd0: bswap = {24'h0, v[7:0]};
      2'd1: bswap = {16'h0, v[7:0], v[15:8]};
      default: bswap = {v[7:0], v[15:8], v[23:16], v[31:24]};
    endcase
  endfunction

  function automatic bit legal_exp(input logic [11:0] o, input logic [1:0] s);
    logic [11:0] b;
    b = {o[11:2], 2'b00};
    if (s == 2'd3) return 0;
    if (b == 12'h064) return (s == 2'd2) && (o[1:0] == 2'b00);
    if (b == 12'h068 || b == 12'h06C)
      return (s == 2'd0) || (s == 2'd1 && !o[0]) || (s == 2'd2 && o[1:0] == 2'b00);
    return 0;
  endfunction

  task automatic t_reset();
    logic [31:0] rd; logic er; int lat;
    chk(rsp == 1'b0, "R1 rsp low", {31'h0, rsp}, 0);
    chk(dn_req == 1'b0, "R1 dn_req low", {31'h0, dn_req}, 0);
    access(12'h064, 2'd2, 1'b0, 0, rd, er, lat);
    chk(rd == 32'h0 && !er, "R1 areg reset", rd, 0);
  endtask

  task automatic t_areg();
    logic [31:0] rd; logic er; int lat; int c0;
    c0 = dn_count;
    access(12'h064, 2'd2, 1'b1, 32'hDEAD_BEEF, rd, er, lat);
    chk(!er, "R2 write ok", {31'h0, er}, 0);
    access(12'h064, 2'd2, 1'b0, 0, rd, er, lat);
    chk(rd == 32'hDEAD_BEEF, "R2 readback", rd, 32'hDEAD_BEEF);
    chk(dn_count == c0, "R2 no downstream", dn_count, c0);
    chk(lat == 1, "R9 areg latency", lat, 1);
  endtask

  task automatic t_cfg();
    logic [31:0] rd; logic er; int lat;
    access(12'h064, 2'd2, 1'b1, 32'h8000_1200, rd, er, lat);
    access(12'h06B, 2'd0, 1'b1, 32'hFFFF_FF5A, rd, er, lat);
    chk(cap_addr == 32'h8000_1203, "R3 cfg byte addr", cap_addr, 32'h8000_1203);
    chk(cap_space == 1'b0 && cap_we && cap_size == 2'd0, "R3 cfg space/dir/size",
        {29'h0, cap_space, cap_size}, 0);
    chk(cap_wdata == 32'h0000_005A, "R4 cfg byte wdata", cap_wdata, 32'h5A);
    access(12'h068, 2'd2, 1'b1, 32'h1122_3344, rd, er, lat);
    chk(cap_wdata == 32'h1122_3344, "R4 cfg word wdata", cap_wdata, 32'h1122_3344);
    chk(cap_addr == 32'h8000_1200, "R3 cfg word addr", cap_addr, 32'h8000_1200);
    resp_data = 32'hAABB_CCDD;
    access(12'h06A, 2'd1, 1'b0, 0, rd, er, lat);
    chk(rd == 32'h0000_CCDD, "R4 cfg half read", rd, 32'hCCDD);
    chk(cap_addr == 32'h8000_1202 && !cap_we, "R3 cfg half addr", cap_addr, 32'h8000_1202);
  endtask

  task automatic t_io();
    logic [31:0] rd; logic er; int lat;
    access(12'h064, 2'd2, 1'b1, 32'hABCD_5678, rd, er, lat);
    access(12'h06C, 2'd2, 1'b1, 32'h1122_3344, rd, er, lat);
    chk(cap_addr == 32'h0000_5678 && cap_space, "R5 io addr", cap_addr, 32'h5678);
    chk(cap_wdata == 32'h4433_2211, "R6 io word wdata", cap_wdata, 32'h44332211);
    access(12'h06E, 2'd1, 1'b1, 32'h0000_BEEF, rd, er, lat);
    chk(cap_addr == 32'h0000_5678, "R5 io offset ignored", cap_addr, 32'h5678);
    chk(cap_wdata == 32'h0000_EFBE, "R6 io half wdata", cap_wdata, 32'hEFBE);
    resp_data = 32'h1234_56A5;
    access(12'h06F, 2'd0, 1'b0, 0, rd, er, lat);
    chk(rd == 32'h0000_00A5, "R6 io byte read", rd, 32'hA5);
    resp_data = 32'h0102_0304;
    access(12'h06C, 2'd2, 1'b0, 0, rd, er, lat);
    chk(rd == bswap(32'h0102_0304, 2'd2), "R6 io word read", rd, 32'h04030201);
    resp_data = 32'hFFFF_1234;
    access(12'h06E, 2'd1, 1'b0, 0, rd, er, lat);
    chk(rd == 32'h0000_3412, "R6 io half read", rd, 32'h3412);
  endtask

  task automatic t_legal();
    logic [31:0] rd; logic er; int lat; int c0; bit lg;
    resp_data = 32'h0;
    for (int o = 12'h064; o <= 12'h06F; o++) begin
      for (int s = 0; s < 4; s++) begin
        lg = legal_exp(12'(o), 2'(s));
        c0 = dn_count;
        access(12'(o), 2'(s), 1'b0, 0, rd, er, lat);
        chk(er == !lg, "R7 legality", {20'h0, 12'(o)}, {31'h0, !lg});
        if (o >= 12'h068)
          chk((dn_count - c0) == int'(lg), "R7 request issued", dn_count - c0, int'(lg));
        if (!lg) chk(rd == 32'h0, "R8 reject data", rd, 0);
      end
    end
    c0 = dn_count;
    access(12'h070, 2'd2, 1'b1, 32'h1, rd, er, lat);
    chk(er && rd == 0 && dn_count == c0, "R8 offset 0x070", {31'h0, er}, 1);
    access(12'h060, 2'd2, 1'b0, 0, rd, er, lat);
    chk(er && rd == 0 && dn_count == c0, "R8 offset 0x060", {31'h0, er}, 1);
    access(12'h064, 2'd0, 1'b1, 32'h0, rd, er, lat);
    chk(er && lat == 1, "R8 areg byte reject", {31'h0, er}, 1);
    access(12'h064, 2'd2, 1'b0, 0, rd, er, lat);
    chk(rd == 32'hABCD_5678, "R8 areg untouched", rd, 32'hABCD_5678);
  endtask

  task automatic t_stall();
    logic [31:0] rd; logic er; int lat;
    dly = 3; resp_err = 1'b1;
    access(12'h068, 2'd2, 1'b0, 0, rd, er, lat);
    chk(lat == 5, "R9 stall latency", lat, 5);
    chk(er == 1'b1, "R9 error passed", {31'h0, er}, 1);
    chk(req_cycles == 4, "R10 request held", req_cycles, 4);
    dly = 0; resp_err = 1'b0;
    access(12'h06C, 2'd0, 1'b1, 32'h7, rd, er, lat);
    chk(lat == 2 && !er, "R9 fast latency", lat, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_areg();
    t_cfg();
    t_io();
    t_legal();
    t_stall();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule